// File: doc/BRIEF.md
# Macro Result Assignment and Method Send Unit

This unit sits behind the ALU of a small command-macro processor and decides what happens to each instruction's result. A 3-bit assignment code picks the value written to the destination register: either the ALU result or a parameter popped from an internal argument queue. The code also decides whether a packed method address and increment are loaded from the result, and whether a method beat (12-bit address plus 32-bit data) is sent downstream. After every accepted beat the method address advances by the loaded increment, so a single loaded address can be followed by a run of sends to consecutive or strided methods.

The argument queue is filled through a push port. A pop from an empty queue yields zero and sets a sticky warning. A push into a full queue is dropped and sets a sticky overflow flag. The send port is valid/ready: once `snd_valid` rises, the address and data hold until the beat is taken on a cycle with `snd_ready` high. `busy` stays high for that whole time, and an instruction offered while `busy` is high is not taken. After the handshake the unit is free again on the next cycle.

Top module: `mthd_send_unit`

## Requirements
- R1: After reset `busy`, `snd_valid`, `rf_wr_en`, `arg_empty_pop` and `arg_overflow` are 0, and `mth_addr` and `mth_incr` are 0.
- R2: An instruction is taken on a rising edge with `op_valid`=1 and `busy`=0. During the next cycle `rf_wr_en` is 1, `rf_wr_idx` equals `op_dst`, and `rf_wr_data` is the popped parameter for codes 0, 3 and 5, or `op_result` for codes 1, 2, 4, 6 and 7.
- R3: When `op_dst` is 0, `rf_wr_en` stays 0 and no register write is issued.
- R4: Codes 2, 5, 6 and 7 load `mth_addr` from result bits [11:0] and `mth_incr` from result bits [17:12]. Codes 0, 1, 3 and 4 leave both unchanged.
- R5: Codes 3 and 4 send `op_result` at the current `mth_addr`.
- R6: Code 6 sends a popped parameter, and code 7 sends result bits [17:12] zero-extended. Both send at the address loaded by the same instruction.
- R7: Each send handshake advances `mth_addr` by `mth_incr`, modulo 4096.
- R8: `snd_valid` rises in the cycle after the instruction is taken. While `snd_valid`=1 and `snd_ready`=0, the address and data hold, `busy` is 1, and `op_valid` is ignored. `snd_valid` and `busy` fall in the cycle after the handshake.
- R9: Codes 0, 3, 5 and 6 each pop one parameter, in arrival order. A pop from an empty queue returns 0 and sets `arg_empty_pop`, which stays set until reset.
- R10: A push while the queue holds ARG_DEPTH entries is dropped and sets `arg_overflow`, which stays set until reset. A push and a pop in the same cycle both act on the queue state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction offered |
| op_code | input | 3 | Assignment code |
| op_dst | input | REG_IDX_W | Destination register index |
| op_result | input | DATA_W | ALU result |
| busy | output | 1 | Send pending; instruction issue must stall |
| arg_push | input | 1 | Push a parameter into the queue |
| arg_data | input | DATA_W | Parameter value |
| arg_empty_pop | output | 1 | Sticky: a pop found the queue empty |
| arg_overflow | output | 1 | Sticky: a push was dropped because the queue was full |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | REG_IDX_W | Register write index |
| rf_wr_data | output | DATA_W | Register write data |
| mth_addr | output | ADDR_W | Current method address |
| mth_incr | output | INCR_W | Current method increment |
| snd_valid | output | 1 | Method beat valid |
| snd_ready | input | 1 | Downstream accepts the beat |
| snd_addr | output | ADDR_W | Beat method address |
| snd_data | output | DATA_W | Beat data |

## Verification
The hardest situations to reach are a stalled send while the issuing stage keeps offering an instruction, and a full queue being pushed in the same cycle as a pop. The bench sweeps every assignment code against every destination index and keeps a small queue (depth 4) fed irregularly, so it drains to empty and fills to overflow more than once. For each send it holds `snd_ready` low for a number of cycles that depends on the index, and drives a competing instruction throughout those cycles. Some instructions also carry a push in their own cycle.

// File: rtl/mthd_pkg.sv
package mthd_pkg;

  typedef enum logic [2:0] {
    ASG_POP_DROP    = 3'd0,
    ASG_MOVE        = 3'd1,
    ASG_MOVE_LOAD   = 3'd2,
    ASG_POP_SENDRES = 3'd3,
    ASG_MOVE_SEND   = 3'd4,
    ASG_POP_LOAD    = 3'd5,
    ASG_LOAD_POPSND = 3'd6,
    ASG_LOAD_SNDINC = 3'd7
  } asg_code_e;

  typedef enum logic [1:0] {
    SSEL_RESULT = 2'd0,
    SSEL_PARAM  = 2'd1,
    SSEL_INCR   = 2'd2
  } send_sel_e;

  typedef struct packed {
    logic      pop;
    logic      wr_param;
    logic      load;
    logic      send;
    send_sel_e sel;
  } asg_ctl_t;

  function automatic asg_ctl_t asg_decode(input logic [2:0] code);
    asg_ctl_t c;
    c = '{pop: 1'b0, wr_param: 1'b0, load: 1'b0, send: 1'b0, sel: SSEL_RESULT};
    unique case (asg_code_e'(code))
      ASG_POP_DROP:    begin c.pop = 1'b1; c.wr_param = 1'b1; end
      ASG_MOVE:        ;
      ASG_MOVE_LOAD:   c.load = 1'b1;
      ASG_POP_SENDRES: begin c.pop = 1'b1; c.wr_param = 1'b1; c.send = 1'b1; end
      ASG_MOVE_SEND:   c.send = 1'b1;
      ASG_POP_LOAD:    begin c.pop = 1'b1; c.wr_param = 1'b1; c.load = 1'b1; end
      ASG_LOAD_POPSND: begin c.load = 1'b1; c.pop = 1'b1; c.send = 1'b1; c.sel = SSEL_PARAM; end
      ASG_LOAD_SNDINC: begin c.load = 1'b1; c.send = 1'b1; c.sel = SSEL_INCR; end
      default:         ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mthd_arg_fifo.sv
module mthd_arg_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty_pop,
  output logic         overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          has_data, has_room, do_pop, do_push;

  assign has_data = (cnt != '0);
  assign has_room = (cnt != FULL);
  assign do_pop   = pop && has_data;
  assign do_push  = push && has_room;
  assign pop_data = has_data ? mem[rd_ptr] : '0;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      cnt       <= '0;
      empty_pop <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
      if (pop && !has_data)  empty_pop <= 1'b1;
      if (push && !has_room) overflow  <= 1'b1;
    end
  end

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow);
  // R9
  empty_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) empty_pop |=> empty_pop);
  // R9
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                   (pop && cnt == '0) |-> (pop_data == '0));
endmodule

// File: rtl/mthd_addr_reg.sv
module mthd_addr_reg #(
  parameter int ADDR_W = 12,
  parameter int INCR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [INCR_W-1:0] load_incr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [INCR_W-1:0] incr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      incr <= '0;
    end else if (load) begin
      addr <= load_addr;
      incr <= load_incr;
    end else if (step) begin
      addr <= addr + ADDR_W'(incr);
    end
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                             (!load && !step) |=> ($stable(addr) && $stable(incr)));
  // R7
  step_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                  (step && !load) |=> $stable(incr));
  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                             load |=> (addr == $past(load_addr) && incr == $past(load_incr)));
endmodule

// File: rtl/mthd_send_stage.sv
module mthd_send_stage #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  output logic              snd_valid,
  input  logic              snd_ready,
  output logic [ADDR_W-1:0] snd_addr,
  output logic [DATA_W-1:0] snd_data,
  output logic              done
);
  assign done = snd_valid && snd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snd_valid <= 1'b0;
      snd_addr  <= '0;
      snd_data  <= '0;
    end else if (start) begin
      snd_valid <= 1'b1;
      snd_addr  <= start_addr;
      snd_data  <= start_data;
    end else if (done) begin
      snd_valid <= 1'b0;
    end
  end

  // R8
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && !snd_ready) |=> (snd_valid && $stable(snd_addr) && $stable(snd_data)));
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n) start |-> !snd_valid);
  // R8
  drop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !snd_valid);
endmodule

// File: rtl/mthd_send_unit.sv
module mthd_send_unit
  import mthd_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int INCR_W    = 6,
  parameter int REG_IDX_W = 3,
  parameter int ARG_DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [2:0]           op_code,
  input  logic [REG_IDX_W-1:0] op_dst,
  input  logic [DATA_W-1:0]    op_result,
  output logic                 busy,
  input  logic                 arg_push,
  input  logic [DATA_W-1:0]    arg_data,
  output logic                 arg_empty_pop,
  output logic                 arg_overflow,
  output logic                 rf_wr_en,
  output logic [REG_IDX_W-1:0] rf_wr_idx,
  output logic [DATA_W-1:0]    rf_wr_data,
  output logic [ADDR_W-1:0]    mth_addr,
  output logic [INCR_W-1:0]    mth_incr,
  output logic                 snd_valid,
  input  logic                 snd_ready,
  output logic [ADDR_W-1:0]    snd_addr,
  output logic [DATA_W-1:0]    snd_data
);
  localparam int INCR_LO = ADDR_W;
  localparam int INCR_HI = ADDR_W + INCR_W - 1;

  asg_ctl_t          ctl;
  logic              accept, snd_done;
  logic [DATA_W-1:0] param, beat_data;
  logic [ADDR_W-1:0] beat_addr;

  assign busy   = snd_valid;
  assign accept = op_valid && !busy;
  assign ctl    = asg_decode(op_code);

  mthd_arg_fifo #(.W(DATA_W), .DEPTH(ARG_DEPTH)) u_args (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (arg_push),
    .push_data (arg_data),
    .pop       (accept && ctl.pop),
    .pop_data  (param),
    .empty_pop (arg_empty_pop),
    .overflow  (arg_overflow)
  );

  mthd_addr_reg #(.ADDR_W(ADDR_W), .INCR_W(INCR_W)) u_maddr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && ctl.load),
    .load_addr (op_result[ADDR_W-1:0]),
    .load_incr (op_result[INCR_HI:INCR_LO]),
    .step      (snd_done),
    .addr      (mth_addr),
    .incr      (mth_incr)
  );

  always_comb begin
    beat_addr = ctl.load ? op_result[ADDR_W-1:0] : mth_addr;
    unique case (ctl.sel)
      SSEL_PARAM: beat_data = param;
      SSEL_INCR:  beat_data = DATA_W'(op_result[INCR_HI:INCR_LO]);
      default:    beat_data = op_result;
    endcase
  end

  mthd_send_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_send (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept && ctl.send),
    .start_addr (beat_addr),
    .start_data (beat_data),
    .snd_valid  (snd_valid),
    .snd_ready  (snd_ready),
    .snd_addr   (snd_addr),
    .snd_data   (snd_data),
    .done       (snd_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_wr_en   <= 1'b0;
      rf_wr_idx  <= '0;
      rf_wr_data <= '0;
    end else begin
      rf_wr_en   <= accept && (op_dst != '0);
      rf_wr_idx  <= op_dst;
      rf_wr_data <= ctl.wr_param ? param : op_result;
    end
  end

  // R3
  no_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                      rf_wr_en |-> (rf_wr_idx != '0));
  // R8
  stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                       busy |=> !rf_wr_en);
  // R2
  write_follows_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                         rf_wr_en |-> $past(op_valid));
  // R7
  addr_stable_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                              (busy && !snd_ready) |=> $stable(mth_addr));
endmodule

// File: tb/mthd_send_unit_tb.sv
module mthd_send_unit_tb;
  localparam int DEP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [2:0]  op_dst = '0;
  logic [31:0] op_result = '0;
  logic        busy;
  logic        arg_push = 1'b0;
  logic [31:0] arg_data = '0;
  logic        arg_empty_pop, arg_overflow;
  logic        rf_wr_en;
  logic [2:0]  rf_wr_idx;
  logic [31:0] rf_wr_data;
  logic [11:0] mth_addr;
  logic [5:0]  mth_incr;
  logic        snd_valid;
  logic        snd_ready = 1'b0;
  logic [11:0] snd_addr;
  logic [31:0] snd_data;

  always #4 clk = ~clk;

  mthd_send_unit #(.ARG_DEPTH(DEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_dst(op_dst),
    .op_result(op_result), .busy(busy), .arg_push(arg_push), .arg_data(arg_data),
    .arg_empty_pop(arg_empty_pop), .arg_overflow(arg_overflow), .rf_wr_en(rf_wr_en),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .mth_addr(mth_addr),
    .mth_incr(mth_incr), .snd_valid(snd_valid), .snd_ready(snd_ready),
    .snd_addr(snd_addr), .snd_data(snd_data)
  );

  int nchk = 0;
  int nerr = 0;

  logic [31:0] q [DEP];
  int          qn = 0;
  logic [11:0] m_addr = '0;
  logic [5:0]  m_incr = '0;
  bit          m_warn = 0;
  bit          m_ovf = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic m_push(logic [31:0] v, int pre);
    if (pre < DEP) begin q[qn] = v; qn++; end
    else m_ovf = 1;
  endtask

  task automatic push_one(logic [31:0] v);
    @(negedge clk);
    arg_push = 1'b1; arg_data = v;
    m_push(v, qn);
    @(negedge clk);
    arg_push = 1'b0;
    check("R10", "overflow flag", 32'(arg_overflow), 32'(m_ovf));
  endtask

  task automatic run_op(int code, int dst, logic [31:0] res, bit push_same,
                        logic [31:0] pv, int stall);
    bit pop, wrp, ld, snd;
    int sel, pre;
    logic [31:0] popv, wexp, sd;
    logic [11:0] sa;
    pop = (code == 0 || code == 3 || code == 5 || code == 6);
    wrp = (code == 0 || code == 3 || code == 5);
    ld  = (code == 2 || code == 5 || code == 6 || code == 7);
    snd = (code == 3 || code == 4 || code == 6 || code == 7);
    sel = (code == 6) ? 1 : (code == 7) ? 2 : 0;
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'(code); op_dst = 3'(dst); op_result = res;
    arg_push = push_same; arg_data = pv;
    pre = qn; popv = '0;
    if (pop) begin
      if (qn > 0) begin
        popv = q[0];
        for (int i = 1; i < DEP; i++) q[i-1] = q[i];
        qn--;
      end else m_warn = 1;
    end
    if (push_same) m_push(pv, pre);
    wexp = wrp ? popv : res;
    sa = ld ? res[11:0] : m_addr;
    if (ld) begin m_addr = res[11:0]; m_incr = res[17:12]; end
    sd = (sel == 1) ? popv : (sel == 2) ? {26'd0, res[17:12]} : res;
    @(negedge clk);
    op_valid = 1'b0; arg_push = 1'b0;
    check(dst == 0 ? "R3" : "R2", "wr_en", 32'(rf_wr_en), 32'(dst != 0));
    if (dst != 0) begin
      check("R2", "wr_idx", 32'(rf_wr_idx), 32'(dst));
      check(wrp ? "R9" : "R2", "wr_data", rf_wr_data, wexp);
    end
    check("R4", "mth_addr", 32'(mth_addr), 32'(m_addr));
    check("R4", "mth_incr", 32'(mth_incr), 32'(m_incr));
    check("R9", "empty_pop flag", 32'(arg_empty_pop), 32'(m_warn));
    check("R10", "overflow flag", 32'(arg_overflow), 32'(m_ovf));
    check("R8", "snd_valid", 32'(snd_valid), 32'(snd));
    if (snd) begin
      check("R8", "busy", 32'(busy), 32'd1);
      check(ld ? "R6" : "R5", "snd_addr", 32'(snd_addr), 32'(sa));
      check(ld ? "R6" : "R5", "snd_data", snd_data, sd);
      for (int s = 0; s < stall; s++) begin
        op_valid = 1'b1; op_code = 3'd1; op_dst = 3'd1; op_result = 32'hDEAD_0000;
        @(negedge clk);
        check("R8", "write while busy", 32'(rf_wr_en), 32'd0);
        check("R8", "held valid", 32'(snd_valid), 32'd1);
        check("R8", "held addr", 32'(snd_addr), 32'(sa));
        check("R8", "held data", snd_data, sd);
      end
      op_valid = 1'b0; snd_ready = 1'b1;
      @(negedge clk);
      snd_ready = 1'b0;
      m_addr = m_addr + 12'(m_incr);
      check("R8", "valid after handshake", 32'(snd_valid), 32'd0);
      check("R8", "busy after handshake", 32'(busy), 32'd0);
      check("R7", "advanced addr", 32'(mth_addr), 32'(m_addr));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R8 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy", 32'(busy), 32'd0);
    check("R1", "snd_valid", 32'(snd_valid), 32'd0);
    check("R1", "wr_en", 32'(rf_wr_en), 32'd0);
    check("R1", "flags", {30'd0, arg_empty_pop, arg_overflow}, 32'd0);
    check("R1", "addr/incr", {14'd0, mth_incr, mth_addr}, 32'd0);

    for (int c = 0; c < 8; c++) begin
      for (int d = 0; d < 8; d++) begin
        logic [31:0] r;
        r = 32'h5A00_0000 + 32'(c) * 32'h0004_1203 + 32'(d) * 32'h0001_9F51;
        if (d % 3 != 0) push_one(32'hC000_0000 + 32'(c * 16 + d));
        run_op(c, d, r, d == 5, 32'hB000_0000 + 32'(c * 16 + d), d % 3);
      end
    end
    // wrap of the 12-bit address: load 0xFF0 with increment 63 and send twice
    run_op(7, 2, 32'h0003_FFF0, 1'b0, '0, 0);
    run_op(4, 3, 32'h1234_5678, 1'b0, '0, 1);
    run_op(4, 0, 32'h0BAD_F00D, 1'b0, '0, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule